// File: doc/BRIEF.md
# Seven-bit single-error-correcting codec

This block protects a four-bit data word with three parity bits inside a seven-bit codeword. The encoder half is purely combinational: a data nibble presented at its input appears as a codeword in the same cycle. Each parity bit sits at a power-of-two position, and the data bits fill the positions in between.

The decoder half takes a codeword with a valid strobe. It computes a three-bit syndrome, and that syndrome is the 1-based position of a single inverted bit, or zero when the word is clean. The decoder inverts the bit the syndrome points to and extracts the data. One clock later it presents the data, the syndrome and a flag that tells whether a repair took place. Two or more inverted bits lead to a wrong repair, and nothing flags that case. The encoder and decoder share no state, so a single instance can write-protect and read-check in the same cycle.

Top module: `hm74_codec`

## Requirements
- R1: Codeword bit index i (0-based) holds position i+1. Positions 7, 6, 5 and 3 carry data bits 3, 2, 1 and 0 respectively. Positions 4, 2 and 1 carry parity bits 2, 1 and 0.
- R2: Parity bit 0 = d3^d1^d0, parity bit 1 = d3^d2^d0 and parity bit 2 = d3^d2^d1. The encoder output follows its input in the same cycle.
- R3: Syndrome bit k is the XOR of all codeword positions whose number has bit k set. A clean codeword therefore decodes to syndrome 0, its own data, and a clear repair flag.
- R4: When exactly one data position (3, 5, 6 or 7) is inverted, the syndrome equals that position number and the original data is returned.
- R5: When exactly one parity position (1, 2 or 4) is inverted, the syndrome equals that position, the data output is unaltered, and the repair flag still rises.
- R6: The valid output is the valid input delayed by exactly one clock. The data and syndrome belonging to a word appear on that same cycle.
- R7: The repair flag is high only on a cycle where the valid output is high and the syndrome output is nonzero, and it is always high on such a cycle.
- R8: While reset (active low) is held, the valid output, repair flag, data and syndrome outputs are all zero.
- R9: With two inverted positions a and b, the syndrome is a XOR b. The data returned is what results from inverting that position as well, and no error is signalled beyond the normal repair flag.
- R10: On a cycle with the valid input low, the data and syndrome outputs keep their previous values, and the valid output and repair flag go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_data_i | input | 4 | Data nibble to encode |
| enc_code_o | output | 7 | Codeword for enc_data_i, combinational |
| dec_valid_i | input | 1 | dec_code_i holds a word to check |
| dec_code_i | input | 7 | Codeword read back, possibly corrupted |
| dec_valid_o | output | 1 | Decoder outputs hold a new result |
| dec_data_o | output | 4 | Repaired data nibble |
| dec_syndrome_o | output | 3 | Position of the inverted bit, 0 if none |
| dec_fixed_o | output | 1 | A nonzero syndrome was acted on |

## Verification
Encoding and decoding can occur in the same cycle, because the two paths share the module but no state. The bench drives a fresh data nibble into the encoder on every cycle of the decoder sweep, and that nibble is unrelated to the word being decoded. Each encoder output is judged against an explicit parity formula. The decoder result from the previous cycle is judged at the same sample against syndrome and data values that the bench derives by flipping positions itself. Repair and syndrome reporting also coincide in every corrupted-word cycle, and the flag is checked there together with the position.

// File: rtl/hm74_pkg.sv
package hm74_pkg;
  localparam int DATA_W = 4;
  localparam int SYN_W  = 3;
  localparam int CODE_W = DATA_W + SYN_W;

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [SYN_W-1:0]  syn_t;
  typedef logic [CODE_W-1:0] code_t;

  // position p (1-based) is a parity slot when it is a power of two
  function automatic logic is_parity_pos(int p);
    return (p & (p - 1)) == 0;
  endfunction

  // scatter data bits into the non-parity slots, lowest first
  function automatic code_t scatter(data_t d);
    code_t c;
    int idx;
    c = '0;
    idx = 0;
    for (int p = 1; p <= CODE_W; p++) begin
      if (!is_parity_pos(p)) begin
        c[p-1] = d[idx];
        idx++;
      end
    end
    return c;
  endfunction

  // gather data bits back out of the non-parity slots
  function automatic data_t gather(code_t c);
    data_t d;
    int idx;
    d = '0;
    idx = 0;
    for (int p = 1; p <= CODE_W; p++) begin
      if (!is_parity_pos(p)) begin
        d[idx] = c[p-1];
        idx++;
      end
    end
    return d;
  endfunction

  // bit k: XOR of every position whose number has bit k set
  function automatic syn_t syndrome(code_t c);
    syn_t s;
    s = '0;
    for (int p = 1; p <= CODE_W; p++) begin
      for (int k = 0; k < SYN_W; k++) begin
        if (p[k]) s[k] = s[k] ^ c[p-1];
      end
    end
    return s;
  endfunction

  // parity slots are zero after scatter, so syndrome yields their values
  function automatic code_t encode(data_t d);
    code_t c;
    syn_t  s;
    c = scatter(d);
    s = syndrome(c);
    for (int k = 0; k < SYN_W; k++) c[(1 << k) - 1] = s[k];
    return c;
  endfunction
endpackage

// File: rtl/hm74_encoder.sv
module hm74_encoder
  import hm74_pkg::*;
(
  input  data_t data_i,
  output code_t code_o
);
  always_comb code_o = encode(data_i);
endmodule

// File: rtl/hm74_syndrome.sv
module hm74_syndrome
  import hm74_pkg::*;
(
  input  code_t code_i,
  output syn_t  syn_o,
  output logic  hit_o
);
  always_comb begin
    syn_o = syndrome(code_i);
    hit_o = |syn_o;
  end
endmodule

// File: rtl/hm74_corrector.sv
module hm74_corrector
  import hm74_pkg::*;
(
  input  code_t code_i,
  input  syn_t  syn_i,
  output code_t mask_o,
  output data_t data_o
);
  code_t fixed_code;

  for (genvar i = 0; i < CODE_W; i++) begin : g_flip
    assign mask_o[i] = (syn_i == SYN_W'(i + 1));
  end

  assign fixed_code = code_i ^ mask_o;
  assign data_o     = gather(fixed_code);
endmodule

// File: rtl/hm74_codec.sv
module hm74_codec
  import hm74_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] enc_data_i,
  output logic [CODE_W-1:0] enc_code_o,
  input  logic              dec_valid_i,
  input  logic [CODE_W-1:0] dec_code_i,
  output logic              dec_valid_o,
  output logic [DATA_W-1:0] dec_data_o,
  output logic [SYN_W-1:0]  dec_syndrome_o,
  output logic              dec_fixed_o
);
  syn_t  raw_syn;
  logic  raw_hit;
  code_t flip_mask;
  data_t raw_data;

  hm74_encoder u_enc (
    .data_i (enc_data_i),
    .code_o (enc_code_o)
  );

  hm74_syndrome u_syn (
    .code_i (dec_code_i),
    .syn_o  (raw_syn),
    .hit_o  (raw_hit)
  );

  hm74_corrector u_fix (
    .code_i (dec_code_i),
    .syn_i  (raw_syn),
    .mask_o (flip_mask),
    .data_o (raw_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid_o    <= 1'b0;
      dec_fixed_o    <= 1'b0;
      dec_data_o     <= '0;
      dec_syndrome_o <= '0;
    end else begin
      dec_valid_o <= dec_valid_i;
      dec_fixed_o <= dec_valid_i & raw_hit;
      if (dec_valid_i) begin
        dec_data_o     <= raw_data;
        dec_syndrome_o <= raw_syn;
      end
    end
  end
endmodule

// File: rtl/hm74_checker.sv
module hm74_checker
  import hm74_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input data_t enc_data_i,
  input code_t enc_code_o,
  input logic  dec_valid_i,
  input code_t dec_code_i,
  input logic  dec_valid_o,
  input data_t dec_data_o,
  input syn_t  dec_syndrome_o,
  input logic  dec_fixed_o,
  input syn_t  raw_syn,
  input code_t flip_mask
);
  assert_enc_place_R1: assert property (@(posedge clk) disable iff (!rst_n)
    gather(enc_code_o) == enc_data_i);

  assert_enc_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
    syndrome(enc_code_o) == '0);

  assert_syn_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_i |=> dec_syndrome_o == $past(raw_syn));

  assert_mask_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flip_mask));

  assert_parity_fix_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_i |=> (!(dec_syndrome_o == 3'd1 || dec_syndrome_o == 3'd2 ||
                       dec_syndrome_o == 3'd4) ||
                     dec_data_o == {$past(dec_code_i[6]), $past(dec_code_i[5]),
                                    $past(dec_code_i[4]), $past(dec_code_i[2])}));

  assert_valid_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_i |=> dec_valid_o);

  assert_valid_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid_i |=> !dec_valid_o);

  assert_flag_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_o |-> (dec_fixed_o == (dec_syndrome_o != '0)));

  assert_flag_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid_o |-> !dec_fixed_o);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid_i |=> ($stable(dec_data_o) && $stable(dec_syndrome_o)));
endmodule

bind hm74_codec hm74_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .enc_data_i     (enc_data_i),
  .enc_code_o     (enc_code_o),
  .dec_valid_i    (dec_valid_i),
  .dec_code_i     (dec_code_i),
  .dec_valid_o    (dec_valid_o),
  .dec_data_o     (dec_data_o),
  .dec_syndrome_o (dec_syndrome_o),
  .dec_fixed_o    (dec_fixed_o),
  .raw_syn        (raw_syn),
  .flip_mask      (flip_mask)
);

// File: tb/sim_hm74_codec.sv
module sim_hm74_codec;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] enc_data_i = '0;
  logic [6:0] enc_code_o;
  logic       dec_valid_i = 1'b0;
  logic [6:0] dec_code_i = '0;
  logic       dec_valid_o;
  logic [3:0] dec_data_o;
  logic [2:0] dec_syndrome_o;
  logic       dec_fixed_o;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;

  always #5 clk = ~clk;

  hm74_codec u0 (.*);

  // explicit parity formulas, written independently of the design
  function automatic logic [6:0] ref_enc(logic [3:0] d);
    return {d[3], d[2], d[1], d[3]^d[2]^d[1], d[0], d[3]^d[2]^d[0], d[3]^d[1]^d[0]};
  endfunction

  function automatic logic [3:0] ref_data(logic [6:0] c);
    return {c[6], c[5], c[4], c[2]};
  endfunction

  function automatic logic [6:0] pos_bit(int p);
    return (p == 0) ? 7'd0 : 7'(1 << (p - 1));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [3:0] nib;
    logic [6:0] sent;
    logic [3:0] exp_d;
    logic [2:0] exp_s;
    logic       pend;
    string      tag;
    int         cyc;

    // R8: reset state
    repeat (3) @(negedge clk);
    chk("R8 valid", 32'(dec_valid_o), 0);
    chk("R8 flag", 32'(dec_fixed_o), 0);
    chk("R8 data", 32'(dec_data_o), 0);
    chk("R8 syn", 32'(dec_syndrome_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // single errors streamed back to back; encoder driven at the same time
    pend = 0;
    exp_d = '0; exp_s = '0; tag = "";
    cyc = 0;
    for (int d = 0; d < 16; d++) begin
      for (int p = 0; p <= 7; p++) begin
        // check result of the word sent on the previous cycle
        if (pend) begin
          chk({tag, " valid R6"}, 32'(dec_valid_o), 1);
          chk({tag, " syn"}, 32'(dec_syndrome_o), 32'(exp_s));
          chk({tag, " data"}, 32'(dec_data_o), 32'(exp_d));
          chk({tag, " flag R7"}, 32'(dec_fixed_o), 32'(exp_s != 0));
        end
        nib = 4'((d * 7 + p * 3 + 5) % 16);
        enc_data_i = nib;
        sent = ref_enc(4'(d)) ^ pos_bit(p);
        dec_code_i = sent;
        dec_valid_i = 1'b1;
        exp_d = 4'(d);
        exp_s = 3'(p);
        tag = (p == 0) ? "R3" : ((p == 1 || p == 2 || p == 4) ? "R5" : "R4");
        pend = 1;
        #1;
        chk("R2 encode", 32'(enc_code_o), 32'(ref_enc(nib)));
        chk("R1 placement", 32'(ref_data(enc_code_o)), 32'(nib));
        @(negedge clk);
        cyc++;
      end
    end
    chk({tag, " syn"}, 32'(dec_syndrome_o), 32'(exp_s));
    chk({tag, " data"}, 32'(dec_data_o), 32'(exp_d));

    // R10: idle cycles hold data and syndrome, drop valid and flag
    dec_valid_i = 1'b0;
    dec_code_i = ref_enc(4'hA) ^ 7'b0001000;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10 valid", 32'(dec_valid_o), 0);
      chk("R10 flag", 32'(dec_fixed_o), 0);
      chk("R10 data", 32'(dec_data_o), 32'(exp_d));
      chk("R10 syn", 32'(dec_syndrome_o), 32'(exp_s));
      dec_code_i = dec_code_i ^ 7'b0100001;
    end

    // R9: double errors give syndrome a^b and a miscorrection
    for (int d = 0; d < 16; d++) begin
      for (int a = 1; a <= 7; a++) begin
        for (int b = a + 1; b <= 7; b++) begin
          sent = ref_enc(4'(d)) ^ pos_bit(a) ^ pos_bit(b);
          dec_code_i = sent;
          dec_valid_i = 1'b1;
          @(negedge clk);
          dec_valid_i = 1'b0;
          chk("R9 syn", 32'(dec_syndrome_o), 32'(a ^ b));
          chk("R9 data", 32'(dec_data_o), 32'(ref_data(sent ^ pos_bit(a ^ b))));
          chk("R9 flag R7", 32'(dec_fixed_o), 1);
          @(negedge clk);
          chk("R6 drop", 32'(dec_valid_o), 0);
        end
      end
    end

    finish_run();
  end
endmodule